// File: doc/BRIEF.md
# Power mode controller

This block holds the power-control register of a small 8-bit microcontroller and turns its contents into clock-gating enables. Software reaches it through the special-function register bus at address 0x87. The register holds six general-purpose flags and two trigger bits, one for Idle and one for Stop. Idle removes only the CPU clock. Stop turns off the internal oscillator, and with it the CPU and the digital peripherals.

A trigger does not act on the cycle it is written. It waits until the core reports that the writing instruction has completed. Any enabled interrupt request ends Idle. Stop ends only through a reset, which can come from the external reset pin or from the built-in missing-clock detector. The detector counts free-running reference cycles and restarts its count on every observed edge of the monitored clock. If `TIMEOUT` cycles pass without an edge while the detector is enabled, it pulses an internal reset. That reset returns the block to its reset state.

All logic runs on the free-running reference clock `clk`. The enables drive clock gates elsewhere on the chip.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, a read at address 0x87 returns 0x00, `mode` is 0 (run), `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, and `mcd_rst` is 0.
- R2: A write at address 0x87 stores data bits 7..2 as flags, and they read back in the same positions. Reads at any other address return 0x00, and writes to any other address change nothing. The flags have no effect on the mode.
- R3: Register bits 1 (Stop trigger) and 0 (Idle trigger) always read as 0.
- R4: A trigger takes effect at the first clock edge with `insn_done` high that follows the edge that captured the write. A write that coincides with `insn_done` waits for the next `insn_done`. Until then `mode` stays 0.
- R5: In Idle (`mode` = 1), `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1. The flags are kept.
- R6: In Stop (`mode` = 2), `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R7: When one write sets both trigger bits, the block enters Stop.
- R8: In Idle, any bit of `irq_req` returns `mode` to 0 at the next clock edge.
- R9: Stop ignores `irq_req`. Only `rst_n` low or a missing-clock reset leaves it, and both return the block to the R1 state.
- R10: While `det_en` is high, `TIMEOUT` consecutive edges with `mon_tick` low make `mcd_rst` high for one cycle, and the register state is reset. A `mon_tick` pulse restarts the count. With `det_en` low, the detector never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Read data, combinational on `sfr_addr` |
| insn_done | input | 1 | Core reports that an instruction has completed |
| irq_req | input | IRQ_W | Enabled interrupt requests |
| det_en | input | 1 | Missing-clock detector enable |
| mon_tick | input | 1 | One-cycle strobe for each edge seen on the monitored clock |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Digital peripheral clock enable |
| osc_en | output | 1 | Internal oscillator enable |
| mcd_rst | output | 1 | One-cycle internal reset from the detector |
| mode | output | 2 | Current mode: 0 run, 1 idle, 2 stop |

## Verification
Read data is combinational, so a flag write shows on `sfr_rdata` one edge after the write strobe. A mode change appears one edge after the `insn_done` or interrupt cycle that causes it. `mcd_rst` rises on the `TIMEOUT`-th edge counted from enable or from the last tick. The bench drives inputs on falling edges and samples one falling edge after each cause, so every check falls in the exact cycle the result is due. Checks in the cycles just before each due edge confirm that nothing moves early.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int          TIMEOUT  = 12500,
  parameter int          IRQ_W    = 4,
  parameter logic [7:0]  SFR_ADDR = 8'h87
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       sfr_addr,
  input  logic             sfr_wr,
  input  logic [7:0]       sfr_wdata,
  output logic [7:0]       sfr_rdata,
  input  logic             insn_done,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic             det_en,
  input  logic             mon_tick,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             mcd_rst,
  output logic [1:0]       mode
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] M_RUN = 2'd0, M_IDLE = 2'd1, M_STOP = 2'd2;

  logic [CW-1:0] cnt;
  logic [5:0]    flags;
  logic [1:0]    pend;
  logic [1:0]    mode_q;

  wire sel  = (sfr_addr == SFR_ADDR);
  wire hit  = sfr_wr && sel;
  wire fire = det_en && !mon_tick && (cnt == CW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        cnt <= '0;
    else if (!det_en || mon_tick || fire) cnt <= '0;
    else                               cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mcd_rst <= 1'b0;
    else        mcd_rst <= fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     flags <= '0;
    else if (fire)  flags <= '0;
    else if (hit)   flags <= sfr_wdata[7:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 pend <= '0;
    else if (fire)              pend <= '0;
    else if (mode_q != M_RUN)   pend <= '0;
    else if (hit)               pend <= sfr_wdata[1:0];
    else if (insn_done)         pend <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     mode_q <= M_RUN;
    else if (fire)  mode_q <= M_RUN;
    else
      case (mode_q)
        M_RUN:   if (insn_done && pend[1])      mode_q <= M_STOP;
                 else if (insn_done && pend[0]) mode_q <= M_IDLE;
        M_IDLE:  if (|irq_req)                  mode_q <= M_RUN;
        default: mode_q <= M_STOP;
      endcase

  assign sfr_rdata     = sel ? {flags, 2'b00} : 8'h00;
  assign mode          = mode_q;
  assign cpu_clk_en    = (mode_q == M_RUN);
  assign periph_clk_en = (mode_q != M_STOP);
  assign osc_en        = (mode_q != M_STOP);

  // R4
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !insn_done) |=> (mode_q == M_RUN));
  // R8
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && |irq_req) |=> (mode_q == M_RUN));
  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP) |=> (mode_q == M_STOP || mcd_rst));
  // R10
  mcd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcd_rst |-> $past(det_en));
  // R10
  mcd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcd_rst |=> !mcd_rst);
  // R10
  mcd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcd_rst |-> (mode_q == M_RUN && flags == 6'd0));
endmodule

// File: tb/pwr_mode_ctl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctl_test;
  localparam int TO = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic sfr_wr = 0, insn_done = 0, det_en = 0, mon_tick = 0;
  logic [IW-1:0] irq_req = 0;
  logic cpu_clk_en, periph_clk_en, osc_en, mcd_rst;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctl #(.TIMEOUT(TO), .IRQ_W(IW), .SFR_ADDR(8'h87)) uut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .insn_done(insn_done),
    .irq_req(irq_req), .det_en(det_en), .mon_tick(mon_tick),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .mcd_rst(mcd_rst), .mode(mode));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    sfr_addr = a; #1; chk(req, sfr_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic with_done = 0);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_wr = 1; insn_done = with_done;
    @(negedge clk); sfr_wr = 0; insn_done = 0;
  endtask

  task automatic enables(string req, logic [1:0] m);
    chk(req, {6'd0, mode}, {6'd0, m});
    chk(req, {5'd0, cpu_clk_en, periph_clk_en, osc_en},
        {5'd0, m == 2'd0, m != 2'd2, m != 2'd2});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1
    rd("R1", 8'h87, 8'h00);
    enables("R1", 2'd0);
    chk("R1", {7'd0, mcd_rst}, 8'd0);

    // R2 flag sweep
    for (int f = 0; f < 64; f++) begin
      wr(8'h87, {f[5:0], 2'b00});
      rd("R2", 8'h87, {f[5:0], 2'b00});
      chk("R2", {6'd0, mode}, 8'd0);
    end
    wr(8'h87, 8'h28);
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h87) continue;
      wr(a[7:0], 8'hFF);
      rd("R2", a[7:0], 8'h00);
      rd("R2", 8'h87, 8'h28);
    end
    @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
    enables("R2", 2'd0);

    // R3
    wr(8'h87, 8'hFF);
    rd("R3", 8'h87, 8'hFC);
    wr(8'h87, 8'h03);
    rd("R3", 8'h87, 8'h00);
    wr(8'h87, 8'h00);

    // R4 write coinciding with insn_done
    wr(8'h87, 8'h01, 1);
    enables("R4", 2'd0);
    @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
    enables("R4", 2'd1);
    @(negedge clk); irq_req = 1; @(negedge clk); irq_req = 0;
    enables("R8", 2'd0);

    // R4-R9 sweep over trigger values and delays
    for (int m = 1; m < 4; m++) begin
      for (int d = 0; d < 4; d++) begin
        logic [1:0] exp_m;
        exp_m = m[1] ? 2'd2 : 2'd1;
        wr(8'h87, {6'h15, m[1:0]});
        enables("R4", 2'd0);
        for (int k = 0; k < d; k++) begin
          @(negedge clk); enables("R4", 2'd0);
        end
        insn_done = 1; @(negedge clk); insn_done = 0;
        if (m == 3) enables("R7", exp_m);
        else if (m == 1) enables("R5", exp_m);
        else enables("R6", exp_m);
        if (exp_m == 2'd1) begin
          rd("R5", 8'h87, 8'h54);
          @(negedge clk); enables("R5", 2'd1);
          irq_req = IW'(1 << (d % IW)); @(negedge clk); irq_req = 0;
          enables("R8", 2'd0);
        end else begin
          irq_req = '1;
          repeat (3) @(negedge clk);
          irq_req = 0;
          enables("R9", 2'd2);
          do_reset();
          enables("R9", 2'd0);
          rd("R9", 8'h87, 8'h00);
        end
      end
    end

    // R10 detector disabled: no firing
    mon_tick = 0; det_en = 0;
    for (int k = 0; k < 3 * TO; k++) begin
      @(negedge clk); chk("R10", {7'd0, mcd_rst}, 8'd0);
    end
    // R10 stop ended by detector
    wr(8'h87, 8'hA2);
    @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
    enables("R6", 2'd2);
    det_en = 1;
    for (int k = 1; k < TO; k++) begin
      @(negedge clk); chk("R10", {7'd0, mcd_rst}, 8'd0);
    end
    @(negedge clk);
    chk("R10", {7'd0, mcd_rst}, 8'd1);
    enables("R10", 2'd0);
    rd("R10", 8'h87, 8'h00);
    @(negedge clk);
    chk("R10", {7'd0, mcd_rst}, 8'd0);
    // R10 tick restarts count
    for (int k = 0; k < TO - 4; k++) @(negedge clk);
    mon_tick = 1; @(negedge clk); mon_tick = 0;
    for (int k = 1; k < TO; k++) begin
      @(negedge clk); chk("R10", {7'd0, mcd_rst}, 8'd0);
    end
    @(negedge clk);
    chk("R10", {7'd0, mcd_rst}, 8'd1);
    det_en = 0;
    finish_run();
  end
endmodule